// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the interrupt sources of a register-compatible UART into one request and an identification byte that software reads to learn which source needs service. Three sources are event-driven and held in sticky flags (line error or break, transmit holding register empty, modem status change). The receive sources follow the receive FIFO level: a data-available condition, compared against a programmable threshold when FIFOs are on, and a receive timeout that fires after four idle character times while the FIFO still holds data.

A four-bit enable input masks each source, a fixed priority picks the one to report, and a master enable gates the external interrupt pin. Host accesses (status read, data read, data write, modem-status read, identification read) arrive as one-cycle strobes and retire the source they belong to. The FIFOs, the serial engines and the host bus decoding sit outside.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 with fifo_on low and irq_pin is low.
- R2: Enable bit 0 admits receive data and timeout, bit 1 the holding-empty flag, bit 2 the line flag, bit 3 the modem flag; a disabled source is not reported but its flag keeps its state and shows once enabled.
- R3: With several enabled sources pending, the reported one is chosen in the order line, receive (data before timeout), holding empty, modem.
- R4: Identification bit 0 is 0 when a source is reported and 1 otherwise; bits 7:6 are 11 when fifo_on is high and 00 when low; bits 5:4 are 0.
- R5: Bits 3:1 are 011 for line, 010 for receive data, 110 for timeout, 001 for holding empty, 000 for modem or when nothing is reported.
- R6: A line_evt pulse sets the line flag; only rd_status clears it.
- R7: A thr_empty_evt pulse sets the holding-empty flag; wr_data clears it, and so does rd_ident while holding empty is the reported source; rd_ident while another source is reported leaves it set.
- R8: A modem_evt pulse sets the modem flag; only rd_modem clears it.
- R9: Receive data is pending when fifo_on is low and rx_count is nonzero, or when fifo_on is high and rx_count reaches the level chosen by rx_trig (00:1, 01:4, 10:8, 11:14).
- R10: With fifo_on high and rx_count nonzero, four char_tick pulses without an rx_move or rd_data pulse raise the timeout; rx_move or rd_data restarts the count; no timeout arises with fifo_on low or an empty FIFO.
- R11: irq_pin is high exactly when a source is reported and mcr_out2 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_en | input | 4 | Per-source enable mask |
| fifo_on | input | 1 | FIFO mode select |
| rx_trig | input | 2 | Receive threshold code |
| rx_count | input | COUNT_W | Bytes held in the receive FIFO or holding register |
| char_tick | input | 1 | One pulse per character time |
| rx_move | input | 1 | A character entered or left the receive FIFO |
| line_evt | input | 1 | Line error or break detected |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| modem_evt | input | 1 | Modem status input changed |
| rd_status | input | 1 | Line status register read strobe |
| rd_data | input | 1 | Receive data read strobe |
| wr_data | input | 1 | Transmit data write strobe |
| rd_modem | input | 1 | Modem status read strobe |
| rd_ident | input | 1 | Identification register read strobe |
| mcr_out2 | input | 1 | Master interrupt enable |
| ident | output | 8 | Identification byte |
| irq_pin | output | 1 | Gated interrupt request |

## Verification
The threshold boundaries are probed one byte below and at each level, so an off-by-one comparator reports receive data a byte early or late. The timeout is walked tick by tick, catching a counter that fires at three or five idle times or is not restarted by FIFO traffic. Stacked sources are retired one at a time, which exposes a wrong priority order or a clear strobe wired to the wrong flag. An identification read while the line source hides a pending holding-empty flag checks that the read clears only the reported source.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   typedef enum logic [2:0] {
      ID_MODEM  = 3'b000,
      ID_THRE   = 3'b001,
      ID_RXDATA = 3'b010,
      ID_LINE   = 3'b011,
      ID_TMO    = 3'b110
   } id_code_e;

   // receive threshold for each trigger code
   function automatic int unsigned trig_level(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uirq_evt_latch.sv
module uirq_evt_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad
         $error("uirq_evt_latch: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= (q[i] & ~clr[i]) | set[i];
         end
      end
   endgenerate
endmodule

// File: rtl/uirq_rx_cond.sv
module uirq_rx_cond #(
   parameter int COUNT_W  = 5,
   parameter int TO_CHARS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_on,
   input  logic [1:0]         rx_trig,
   input  logic [COUNT_W-1:0] rx_count,
   input  logic               char_tick,
   input  logic               rx_move,
   input  logic               rd_data,
   output logic               data_rdy,
   output logic               tmo_pend
);
   import uirq_pkg::*;

   localparam int TW = $clog2(TO_CHARS + 1);

   generate
      if (COUNT_W < 4) begin : g_bad_w
         $error("uirq_rx_cond: COUNT_W must reach the top threshold");
      end
      if (TO_CHARS < 1) begin : g_bad_t
         $error("uirq_rx_cond: TO_CHARS must be at least 1");
      end
   endgenerate

   logic          has_data;
   logic [TW-1:0] idle_q;
   logic          idle_sat;

   assign has_data = (rx_count != '0);
   assign idle_sat = (idle_q == TW'(TO_CHARS));

   always_comb begin
      if (fifo_on) data_rdy = (32'(rx_count) >= trig_level(rx_trig));
      else         data_rdy = has_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_q <= '0;
      else if (rx_move || rd_data || !has_data || !fifo_on)
         idle_q <= '0;
      else if (char_tick && !idle_sat)
         idle_q <= idle_q + TW'(1);
   end

   assign tmo_pend = idle_sat && has_data && fifo_on;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio (
   input  logic               req_line,
   input  logic               req_rx,
   input  logic               req_tmo,
   input  logic               req_thre,
   input  logic               req_modem,
   output logic               pend,
   output uirq_pkg::id_code_e code
);
   import uirq_pkg::*;

   always_comb begin
      pend = 1'b1;
      code = ID_MODEM;
      if      (req_line)  code = ID_LINE;
      else if (req_rx)    code = ID_RXDATA;
      else if (req_tmo)   code = ID_TMO;
      else if (req_thre)  code = ID_THRE;
      else if (req_modem) code = ID_MODEM;
      else                pend = 1'b0;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
   parameter int COUNT_W  = 5,
   parameter int TO_CHARS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         int_en,
   input  logic               fifo_on,
   input  logic [1:0]         rx_trig,
   input  logic [COUNT_W-1:0] rx_count,
   input  logic               char_tick,
   input  logic               rx_move,
   input  logic               line_evt,
   input  logic               thr_empty_evt,
   input  logic               modem_evt,
   input  logic               rd_status,
   input  logic               rd_data,
   input  logic               wr_data,
   input  logic               rd_modem,
   input  logic               rd_ident,
   input  logic               mcr_out2,
   output logic [7:0]         ident,
   output logic               irq_pin
);
   import uirq_pkg::*;

   localparam int NFLAG = 3;
   localparam int F_LINE = 0, F_THRE = 1, F_MODEM = 2;

   logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
   logic             data_rdy, tmo_pend, pend;
   id_code_e         code;

   assign flag_set[F_LINE]  = line_evt;
   assign flag_set[F_THRE]  = thr_empty_evt;
   assign flag_set[F_MODEM] = modem_evt;

   assign flag_clr[F_LINE]  = rd_status;
   assign flag_clr[F_THRE]  = wr_data | (rd_ident & pend & (code == ID_THRE));
   assign flag_clr[F_MODEM] = rd_modem;

   uirq_evt_latch #(.N(NFLAG)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .q     (flag_q)
   );

   uirq_rx_cond #(.COUNT_W(COUNT_W), .TO_CHARS(TO_CHARS)) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_on   (fifo_on),
      .rx_trig   (rx_trig),
      .rx_count  (rx_count),
      .char_tick (char_tick),
      .rx_move   (rx_move),
      .rd_data   (rd_data),
      .data_rdy  (data_rdy),
      .tmo_pend  (tmo_pend)
   );

   uirq_prio i_prio (
      .req_line  (flag_q[F_LINE]  & int_en[2]),
      .req_rx    (data_rdy        & int_en[0]),
      .req_tmo   (tmo_pend        & int_en[0]),
      .req_thre  (flag_q[F_THRE]  & int_en[1]),
      .req_modem (flag_q[F_MODEM] & int_en[3]),
      .pend      (pend),
      .code      (code)
   );

   assign ident   = {fifo_on, fifo_on, 2'b00, code, ~pend};
   assign irq_pin = pend & mcr_out2;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
   parameter int COUNT_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [3:0]         int_en,
   input logic               fifo_on,
   input logic [COUNT_W-1:0] rx_count,
   input logic               line_evt,
   input logic               thr_empty_evt,
   input logic               modem_evt,
   input logic               rd_status,
   input logic               wr_data,
   input logic               rd_modem,
   input logic               mcr_out2,
   input logic [7:0]         ident,
   input logic               irq_pin
);
   AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !mcr_out2 |-> !irq_pin); // R11

   AST_FIFO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      ident[7:4] == {fifo_on, fifo_on, 2'b00}); // R4

   AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (ident[3:0] == 4'b1100) |-> (fifo_on && rx_count != '0)); // R10

   AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ident[3:0] == 4'b0110 && !rd_status)
      |=> (ident[3:0] == 4'b0110 || !int_en[2])); // R6

   AST_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !line_evt) |=> (ident[3:0] != 4'b0110)); // R6

   AST_THRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !thr_empty_evt) |=> (ident[3:0] != 4'b0010)); // R7

   AST_MODEM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_modem && !modem_evt) |=> (ident[3:0] != 4'b0000)); // R8
endmodule

bind uart_irq_ident uirq_chk #(.COUNT_W(COUNT_W)) i_chk (.*);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    int_en = '0;
   logic          fifo_on = 1'b0;
   logic [1:0]    rx_trig = '0;
   logic [CW-1:0] rx_count = '0;
   logic          char_tick = 0, rx_move = 0, line_evt = 0, thr_empty_evt = 0;
   logic          modem_evt = 0, rd_status = 0, rd_data = 0, wr_data = 0;
   logic          rd_modem = 0, rd_ident = 0, mcr_out2 = 1'b1;
   logic [7:0]    ident;
   logic          irq_pin;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   uart_irq_ident #(.COUNT_W(CW), .TO_CHARS(4)) i_uart_irq_ident (.*);

   // {fifo_on, rx_trig, rx_count, int_en, expected ident}
   localparam logic [19:0] VEC [12] = '{
      {1'b0, 2'd0, 5'd0,  4'h1, 8'h01},   // R9 non-FIFO empty
      {1'b0, 2'd0, 5'd1,  4'h1, 8'h04},   // R9 non-FIFO one byte
      {1'b0, 2'd0, 5'd1,  4'h0, 8'h01},   // R2 masked
      {1'b1, 2'd0, 5'd1,  4'h1, 8'hC4},   // R9 level 1
      {1'b1, 2'd1, 5'd3,  4'h1, 8'hC1},   // R9 below 4
      {1'b1, 2'd1, 5'd4,  4'h1, 8'hC4},   // R9 at 4
      {1'b1, 2'd2, 5'd7,  4'h1, 8'hC1},   // R9 below 8
      {1'b1, 2'd2, 5'd8,  4'h1, 8'hC4},   // R9 at 8
      {1'b1, 2'd3, 5'd13, 4'h1, 8'hC1},   // R9 below 14
      {1'b1, 2'd3, 5'd14, 4'h1, 8'hC4},   // R9 at 14
      {1'b1, 2'd3, 5'd16, 4'hE, 8'hC1},   // R2 rx bit off
      {1'b1, 2'd0, 5'd0,  4'h1, 8'hC1}    // R4 FIFO idle
   };

   task automatic chk(input logic [7:0] exp_id, input logic exp_pin, input string req);
      n_vec++;
      if (ident !== exp_id || irq_pin !== exp_pin) begin
         n_bad++;
         $display("FAIL %s: ident=%02h pin=%b expected ident=%02h pin=%b",
                  req, ident, irq_pin, exp_id, exp_pin);
      end
   endtask

   task automatic pulse(input int sel);
      case (sel)
         0: char_tick = 1;   1: rx_move = 1;   2: line_evt = 1;
         3: thr_empty_evt = 1; 4: modem_evt = 1; 5: rd_status = 1;
         6: rd_data = 1;     7: wr_data = 1;   8: rd_modem = 1;
         default: rd_ident = 1;
      endcase
      @(negedge clk);
      {char_tick, rx_move, line_evt, thr_empty_evt, modem_evt} = '0;
      {rd_status, rd_data, wr_data, rd_modem, rd_ident} = '0;
      @(negedge clk);
   endtask

   initial begin
      #1600000;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(8'h01, 1'b0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(8'h01, 1'b0, "R1 after reset");

      for (int i = 0; i < 12; i++) begin
         {fifo_on, rx_trig, rx_count, int_en} = VEC[i][19:8];
         @(negedge clk);
         chk(VEC[i][7:0], VEC[i][7:0] != 8'h01 && VEC[i][7:0] != 8'hC1, "R9 R5 vector");
      end

      // holding empty, master gate, clears
      fifo_on = 0; rx_count = 0; int_en = 4'h2;
      pulse(3); chk(8'h02, 1'b1, "R7 thre set");
      mcr_out2 = 0; @(negedge clk); chk(8'h02, 1'b0, "R11 gated");
      mcr_out2 = 1;
      pulse(7); chk(8'h01, 1'b0, "R7 write clears");
      pulse(3); pulse(9); chk(8'h01, 1'b0, "R7 ident read clears");

      // modem
      int_en = 4'h8;
      pulse(4); chk(8'h00, 1'b1, "R8 modem set");
      pulse(5); chk(8'h00, 1'b1, "R8 status read ignored");
      pulse(8); chk(8'h01, 1'b0, "R8 modem read clears");

      // line
      int_en = 4'h4;
      pulse(2); chk(8'h06, 1'b1, "R6 line set");
      pulse(6); chk(8'h06, 1'b1, "R6 data read ignored");
      pulse(5); chk(8'h01, 1'b0, "R6 status read clears");

      // masking keeps the flag
      int_en = 4'h0; pulse(2); chk(8'h01, 1'b0, "R2 line masked");
      int_en = 4'h4; @(negedge clk); chk(8'h06, 1'b1, "R2 line unmasked");
      pulse(5);

      // priority stack
      int_en = 4'hF; pulse(2); pulse(3); pulse(4); rx_count = 1;
      @(negedge clk); chk(8'h06, 1'b1, "R3 line first");
      pulse(9); chk(8'h06, 1'b1, "R7 ident read under line");
      pulse(5); chk(8'h04, 1'b1, "R3 rx second");
      rx_count = 0; @(negedge clk); chk(8'h02, 1'b1, "R3 thre third");
      pulse(7); chk(8'h00, 1'b1, "R3 modem last");
      pulse(8); chk(8'h01, 1'b0, "R3 all clear");

      // timeout
      fifo_on = 1; rx_trig = 2'd3; rx_count = 2; int_en = 4'h1;
      pulse(1);
      for (int k = 0; k < 3; k++) pulse(0);
      chk(8'hC1, 1'b0, "R10 three ticks");
      pulse(0); chk(8'hCC, 1'b1, "R10 fourth tick");
      pulse(1); chk(8'hC1, 1'b0, "R10 move restarts");
      for (int k = 0; k < 4; k++) pulse(0);
      chk(8'hCC, 1'b1, "R10 timeout again");
      pulse(6); chk(8'hC1, 1'b0, "R10 data read restarts");
      rx_count = 0;
      for (int k = 0; k < 5; k++) pulse(0);
      chk(8'hC1, 1'b0, "R10 empty FIFO");
      fifo_on = 0; rx_count = 1;
      for (int k = 0; k < 5; k++) pulse(0);
      chk(8'h04, 1'b1, "R10 no timeout non-FIFO");

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule